// File: doc/BRIEF.md
# Asynchronous Serial Channel with Bit-Rate Clock Output

This block is an 8-bit asynchronous serial transmitter and receiver with a small register port. Bit timing comes from a 16x sampling tick. The tick is produced either by an internal programmable divider from the system clock, or by the rising edges of an external clock pin that runs at sixteen times the bit rate. A free-running sixteen-step phase counter divides the tick down to bit periods. When the internal source is selected with clock output enabled, the counter's top bit is driven out as a bit-rate clock. Its rising edge falls at the centre of every transmitted bit.

Software programs the framing and clock source while both directions are disabled. It then enables the transmitter and/or the receiver, writes bytes to the transmit register, and reads received bytes and status flags back.

Disabling the transmitter flushes the shifter and marks the transmit register empty. Disabling the receiver stops reception but keeps the received byte and all receive flags as they were.

Top module: `sio_async`

## Requirements
- R1: After reset, the status register (address 5) reads 0x01. In that register, bit0 is transmit-empty, bit1 is receive-full, bit2 is parity error, bit3 is framing error and bit4 is overrun. After reset, `txd` is 1 and `sckOe` is 0.
- R2: A transmitted frame is sent least significant bit first, in this order:
  - a 0 start bit;
  - eight data bits;
  - a parity bit, only when mode bit0 is 1 (the bit makes the count of ones even, or odd when mode bit1 is 1);
  - a stop bit of 1, followed by a second stop bit of 1 when mode bit2 is 1.

  Each bit lasts 16 ticks. In internal mode, a tick occurs every (divisor+1) clocks, where the divisor is held at address 1.
- R3: With mode bits [4:3] = 01, `sckOe` is 1 and `sckOut` has a period of one bit. `sckOut` is low for the first 8 ticks of each transmitted bit and rises at that bit's centre.
- R4: With mode bit4 = 1, each rising edge of `sckIn` is one tick, so one bit spans 16 `sckIn` periods, and `sckOe` is 0.
- R5: Writing the transmit register (address 3) clears transmit-empty. The flag sets again when the byte enters the shifter. A byte that is already waiting follows the previous frame with no idle bit between them.
- R6: While transmit enable (control bit0, address 2) is 0, transmit-empty reads 1, the shifter is idle with `txd` at 1, and writes to the transmit register are ignored. Clearing the bit in mid-frame aborts that frame.
- R7: The receiver finds a start bit as a low sample on a tick. It confirms the start bit 8 ticks later, then samples each following bit 16 ticks apart. At the stop bit it stores the byte at address 4 and sets receive-full.
- R8: A received parity bit that disagrees with the selected parity sets the parity-error flag.
- R9: A stop bit sampled as 0 sets the framing-error flag.
- R10: A frame that completes while receive-full is 1 sets overrun and leaves the receive register and the other flags unchanged.
- R11: Clearing receive enable (control bit1) leaves receive-full, parity error, framing error, overrun and the receive register unchanged, and frames arriving while it is 0 are not received.
- R12: Writes to the mode register (address 0) and to the divisor (address 1) have no effect while either enable is 1.
- R13: Writing the status register clears each of flags bit1 to bit4 whose written bit is 0. A written 1 leaves that flag as it is.
- R14: When a transmit-register write falls in the same cycle as the previous byte's move into the shifter, the new byte stays pending with transmit-empty at 0. It is sent right after the moving byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational on addr) |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line |
| sckIn | input | 1 | External 16x clock |
| sckOut | output | 1 | Bit-rate clock output |
| sckOe | output | 1 | Output enable for sckOut |

## Verification
Two events can land in the same cycle: a software write to the transmit register, and the transmitter's hand-off of the pending byte into its shifter at a bit boundary. The bench model predicts the tick and phase counters, so the bench can place a write exactly on the clock edge where the pending byte is loaded. The result is judged in two ways. The bench reads transmit-empty right afterwards and expects 0. The model compares `txd` every clock against a queue holding both frames back to back.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
  localparam int DATA_W    = 8;
  localparam int DIV_W     = 8;
  localparam int ADDR_W    = 3;
  localparam int FRAME_MAX = 12;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

  // control -> datapath
  typedef struct packed {
    logic              txEn;
    logic              rxEn;
    logic              parEn;
    logic              parOdd;
    logic              twoStop;
    logic [1:0]        clkSel;
    logic [DIV_W-1:0]  div;
    logic              divRestart;
    logic              txPend;
    logic [DATA_W-1:0] txByte;
  } sioCfg_t;

  // datapath -> control
  typedef struct packed {
    logic              txLoad;
    logic              rxDone;
    logic [DATA_W-1:0] rxByte;
    logic              rxPerr;
    logic              rxFerr;
  } sioEvt_t;
endpackage

// File: rtl/sio_ctrl.sv
`timescale 1ns/1ps
module sio_ctrl
  import sio_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV = 8'd3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  sioEvt_t           evt,
  output sioCfg_t           cfg,
  output logic [4:0]        flags,
  output logic [DATA_W-1:0] rxHold
);
  logic [4:0]        modeR;
  logic [DIV_W-1:0]  divR;
  logic              txEnR, rxEnR;
  logic [DATA_W-1:0] txBuf;
  logic              tdre, rdrf, perr, ferr, orer;
  logic              locked;

  assign locked = txEnR | rxEnR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR  <= '0;
      divR   <= RST_DIV;
      txEnR  <= 1'b0;
      rxEnR  <= 1'b0;
      txBuf  <= '0;
      tdre   <= 1'b1;
      rdrf   <= 1'b0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
      orer   <= 1'b0;
      rxHold <= '0;
    end else begin
      if (wrEn && addr == A_MODE && !locked) modeR <= wrData[4:0];
      if (wrEn && addr == A_DIV && !locked)  divR  <= wrData[DIV_W-1:0];
      if (wrEn && addr == A_CTRL) begin
        txEnR <= wrData[0];
        rxEnR <= wrData[1];
      end
      // transmit-empty: disable wins, then a write, then a hand-off
      if (!txEnR) tdre <= 1'b1;
      else if (wrEn && addr == A_TX) begin
        tdre  <= 1'b0;
        txBuf <= wrData;
      end else if (evt.txLoad) tdre <= 1'b1;
      // status clear by writing zero
      if (wrEn && addr == A_STAT) begin
        if (!wrData[1]) rdrf <= 1'b0;
        if (!wrData[2]) perr <= 1'b0;
        if (!wrData[3]) ferr <= 1'b0;
        if (!wrData[4]) orer <= 1'b0;
      end
      if (evt.rxDone) begin
        if (rdrf) orer <= 1'b1;
        else begin
          rxHold <= evt.rxByte;
          rdrf   <= 1'b1;
          perr   <= perr | evt.rxPerr;
          ferr   <= ferr | evt.rxFerr;
        end
      end
    end
  end

  always_comb begin
    cfg.txEn       = txEnR;
    cfg.rxEn       = rxEnR;
    cfg.parEn      = modeR[0];
    cfg.parOdd     = modeR[1];
    cfg.twoStop    = modeR[2];
    cfg.clkSel     = modeR[4:3];
    cfg.div        = divR;
    cfg.divRestart = wrEn && addr == A_DIV && !locked;
    cfg.txPend     = ~tdre;
    cfg.txByte     = txBuf;
  end

  assign flags = {orer, ferr, perr, rdrf, tdre};

  always_comb begin
    case (addr)
      A_MODE:  rdData = DATA_W'(modeR);
      A_DIV:   rdData = DATA_W'(divR);
      A_CTRL:  rdData = DATA_W'({rxEnR, txEnR});
      A_RX:    rdData = rxHold;
      A_STAT:  rdData = DATA_W'(flags);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/sio_dpath.sv
`timescale 1ns/1ps
module sio_dpath
  import sio_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  sioCfg_t cfg,
  input  logic    rxd,
  input  logic    sckIn,
  output logic    txd,
  output logic    sckOut,
  output logic    sckOe,
  output logic    tick,
  output sioEvt_t evt
);
  logic [2:0]           sckSync;
  logic [1:0]           rxSync;
  logic [DIV_W-1:0]     divCnt;
  logic [3:0]           phase;
  logic                 boundary;
  logic [FRAME_MAX-1:0] shiftR, txFrame;
  logic [3:0]           bitsLeft, txLen;
  logic                 busy, parBit;
  logic                 rxActive, rxPar, rxSample, rxAbort;
  logic [3:0]           rxCnt, rxIdx, stopIdx;
  logic [DATA_W-1:0]    rxShift;

  // ---- tick source and phase ----
  assign tick     = cfg.clkSel[1] ? (sckSync[1] & ~sckSync[2]) : (divCnt == cfg.div);
  assign boundary = tick && phase == 4'hF;
  assign sckOut   = phase[3];
  assign sckOe    = cfg.clkSel == 2'b01;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      rxSync  <= '1;
      divCnt  <= '0;
      phase   <= '0;
    end else begin
      sckSync <= {sckSync[1:0], sckIn};
      rxSync  <= {rxSync[0], rxd};
      if (cfg.divRestart || divCnt == cfg.div) divCnt <= '0;
      else divCnt <= divCnt + 1'b1;
      if (tick) phase <= phase + 1'b1;
    end
  end

  // ---- transmit ----
  assign parBit  = ^cfg.txByte ^ cfg.parOdd;
  assign txFrame = cfg.parEn ? {2'b11, parBit, cfg.txByte, 1'b0}
                             : {3'b111, cfg.txByte, 1'b0};
  assign txLen   = 4'd10 + {3'b0, cfg.parEn} + {3'b0, cfg.twoStop};
  assign evt.txLoad = cfg.txEn && boundary && (!busy || bitsLeft == 4'd1) && cfg.txPend;
  assign txd     = busy ? shiftR[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitsLeft <= '0;
      shiftR   <= '1;
    end else if (!cfg.txEn) begin
      busy     <= 1'b0;
      bitsLeft <= '0;
      shiftR   <= '1;
    end else if (boundary) begin
      if (!busy || bitsLeft == 4'd1) begin
        if (cfg.txPend) begin
          shiftR   <= txFrame;
          bitsLeft <= txLen;
          busy     <= 1'b1;
        end else busy <= 1'b0;
      end else begin
        shiftR   <= {1'b1, shiftR[FRAME_MAX-1:1]};
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end

  // ---- receive ----
  assign stopIdx    = cfg.parEn ? 4'd10 : 4'd9;
  assign rxSample   = tick && rxActive && rxCnt == 4'd7;
  assign rxAbort    = rxSample && rxIdx == 4'd0 && rxSync[1];
  assign evt.rxDone = cfg.rxEn && rxSample && rxIdx == stopIdx;
  assign evt.rxByte = rxShift;
  assign evt.rxPerr = cfg.parEn && (rxPar != (^rxShift ^ cfg.parOdd));
  assign evt.rxFerr = ~rxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxCnt    <= '0;
      rxIdx    <= '0;
      rxShift  <= '0;
      rxPar    <= 1'b0;
    end else if (!cfg.rxEn) begin
      rxActive <= 1'b0;
    end else if (tick) begin
      if (!rxActive) begin
        if (!rxSync[1]) begin
          rxActive <= 1'b1;
          rxCnt    <= '0;
          rxIdx    <= '0;
        end
      end else begin
        rxCnt <= rxCnt + 1'b1;
        if (rxCnt == 4'd7) begin
          if (rxAbort || evt.rxDone) rxActive <= 1'b0;
          else begin
            rxIdx <= rxIdx + 1'b1;
            if (rxIdx >= 4'd1 && rxIdx <= 4'd8) rxShift <= {rxSync[1], rxShift[DATA_W-1:1]};
            else if (rxIdx == 4'd9) rxPar <= rxSync[1];
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_async.sv
`timescale 1ns/1ps
module sio_async
  import sio_pkg::*;
#(
  parameter logic [DIV_W-1:0] RST_DIV = 8'd3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              txd,
  input  logic              rxd,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe
);
  sioCfg_t           cfg;
  sioEvt_t           evt;
  logic [4:0]        flags;
  logic [DATA_W-1:0] rxHold;
  logic              tick;

  sio_ctrl #(.RST_DIV(RST_DIV)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evt(evt), .cfg(cfg), .flags(flags), .rxHold(rxHold)
  );

  sio_dpath i_dpath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .rxd(rxd), .sckIn(sckIn),
    .txd(txd), .sckOut(sckOut), .sckOe(sckOe), .tick(tick), .evt(evt)
  );
endmodule

// File: rtl/sio_async_chk.sv
`timescale 1ns/1ps
module sio_async_chk
  import sio_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              txEn,
  input logic              rxEn,
  input logic              tick,
  input logic              txLoad,
  input logic              rxDone,
  input logic [4:0]        flags,
  input logic [DATA_W-1:0] rxHold,
  input logic [4+DIV_W:0]  modeVec,
  input logic              txd,
  input logic              sckOut,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr
);
  AST_TX_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN) !txEn |=> txd); // R6
  AST_TDRE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN) !txEn |=> flags[0]); // R6
  AST_SCK_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN) !tick |=> $stable(sckOut)); // R3
  AST_LOAD_SETS_TDRE: assert property (@(posedge clk) disable iff (!rstN) (txLoad && !(wrEn && addr == A_TX)) |=> flags[0]); // R5
  AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN) (rxDone && flags[1]) |=> (flags[4] && $stable(rxHold))); // R10
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rstN) (txEn || rxEn) |=> $stable(modeVec)); // R12
  AST_RXOFF_KEEPS: assert property (@(posedge clk) disable iff (!rstN) (!rxEn && !(wrEn && addr == A_STAT)) |=> ($stable(flags[4:1]) && $stable(rxHold))); // R11
endmodule

bind sio_async sio_async_chk i_chk (
  .clk(clk), .rstN(rstN), .txEn(cfg.txEn), .rxEn(cfg.rxEn), .tick(tick),
  .txLoad(evt.txLoad), .rxDone(evt.rxDone), .flags(flags), .rxHold(rxHold),
  .modeVec({cfg.parEn, cfg.parOdd, cfg.twoStop, cfg.clkSel, cfg.div}),
  .txd(txd), .sckOut(sckOut), .wrEn(wrEn), .addr(addr)
);

// File: tb/test_sio_async.sv
`timescale 1ns/1ps
module test_sio_async;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       txd, sckOut, sckOe;
  logic       rxd = 1'b1;
  logic       sckIn = 1'b0;

  int  nChk = 0, nFail = 0;
  bit  cmpOn = 0, extRun = 0, done = 0;

  sio_async i_sio_async (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .txd(txd), .rxd(rxd), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference (internal clock) ----------------
  int  mDiv = 3, mDivCnt = 0, mPhase = 0;
  bit  mTxEn = 0, mRxEn = 0, mPend = 0, mParEn = 0, mParOdd = 0, mTwo = 0;
  logic [7:0] mByte = '0;
  bit  mQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 3; mDivCnt = 0; mPhase = 0; mTxEn = 0; mRxEn = 0; mPend = 0;
      mParEn = 0; mParOdd = 0; mTwo = 0; mQ.delete();
    end else begin
      bit tk, bnd, lk;
      tk  = (mDivCnt == mDiv);
      bnd = tk && mPhase == 15;
      lk  = mTxEn || mRxEn;
      if (!mTxEn) mQ.delete();
      else if (bnd) begin
        if (mQ.size() <= 1) begin
          mQ.delete();
          if (mPend) begin
            mQ.push_back(1'b0);
            for (int i = 0; i < 8; i++) mQ.push_back(mByte[i]);
            if (mParEn) mQ.push_back(^mByte ^ mParOdd);
            mQ.push_back(1'b1);
            if (mTwo) mQ.push_back(1'b1);
            mPend = 0;
          end
        end else void'(mQ.pop_front());
      end
      if (tk) mPhase = (mPhase + 1) % 16;
      if (wrEn && addr == 3'd1 && !lk) mDivCnt = 0;
      else mDivCnt = tk ? 0 : mDivCnt + 1;
      if (!mTxEn) mPend = 0;
      else if (wrEn && addr == 3'd3) begin mPend = 1; mByte = wrData; end
      if (wrEn && addr == 3'd0 && !lk) begin
        mParEn = wrData[0]; mParOdd = wrData[1]; mTwo = wrData[2];
      end
      if (wrEn && addr == 3'd1 && !lk) mDiv = wrData;
      if (wrEn && addr == 3'd2) begin mTxEn = wrData[0]; mRxEn = wrData[1]; end
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      chk("R2 txd vs model", txd, (mQ.size() != 0) ? mQ[0] : 1'b1);
      chk("R3 sckOut vs model", sckOut, (mPhase >= 8));
    end
  end

  initial forever begin
    repeat (2) @(negedge clk);
    if (extRun) sckIn = ~sckIn;
  end

  // ---------------- bus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdNow(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rdNow(a, v);
  endtask

  task automatic waitPhase(input int p);
    do @(negedge clk); while (mPhase != p);
  endtask

  task automatic waitTxIdle();
    do @(negedge clk); while (mQ.size() != 0 || mPend);
    repeat (4) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] d, input bit par, input bit odd,
                        input bit badPar, input bit badStop);
    rxd = 1'b0; repeat (64) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (64) @(negedge clk); end
    if (par) begin rxd = ^d ^ odd ^ badPar; repeat (64) @(negedge clk); end
    if (badStop) begin rxd = 1'b0; repeat (48) @(negedge clk); rxd = 1'b1; repeat (16) @(negedge clk); end
    else begin rxd = 1'b1; repeat (64) @(negedge clk); end
    rxd = 1'b1; repeat (128) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rdNow(3'd5, v); chk("R1 status after reset", v, 8'h01);
    chk("R1 txd idle", txd, 1'b1);
    chk("R1 sckOe off", sckOe, 1'b0);
    cmpOn = 1;

    wr(3'd0, 8'h09);            // parity even, clock output
    wr(3'd1, 8'd3);
    wr(3'd2, 8'h03);
    chk("R3 sckOe on", sckOe, 1'b1);
    wr(3'd0, 8'h00); rd(3'd0, v); chk("R12 mode locked", v, 8'h09);
    wr(3'd1, 8'd7);  rd(3'd1, v); chk("R12 divisor locked", v, 8'd3);

    // R5 / R3: first frame and its clock phase
    waitPhase(1);
    wr(3'd3, 8'hA5);
    rdNow(3'd5, v); chk("R5 tdre cleared by write", v[0], 1'b0);
    do @(negedge clk); while (txd !== 1'b0);
    chk("R3 sckOut low at bit start", sckOut, 1'b0);
    rdNow(3'd5, v); chk("R5 tdre set on hand-off", v[0], 1'b1);
    repeat (31) @(negedge clk);
    chk("R3 sckOut low before centre", sckOut, 1'b0);
    @(negedge clk);
    chk("R3 sckOut high at centre", sckOut, 1'b1);
    wr(3'd3, 8'h3C);
    rdNow(3'd5, v); chk("R5 tdre while pending", v[0], 1'b0);
    waitTxIdle();

    // R14: write lands on the hand-off edge
    waitPhase(2);
    wr(3'd3, 8'h11);
    do @(negedge clk); while (!(mPhase == 15 && mDivCnt == mDiv));
    addr = 3'd3; wrData = 8'h22; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    rdNow(3'd5, v); chk("R14 tdre stays 0 after coincident write", v[0], 1'b0);
    chk("R14 first byte started", txd, 1'b0);
    waitTxIdle();

    // R2: odd parity, two stop bits
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h0F);
    rd(3'd0, v); chk("R12 mode writable when disabled", v, 8'h0F);
    wr(3'd2, 8'h03);
    waitPhase(3);
    wr(3'd3, 8'h80);
    waitTxIdle();

    // R6: abort mid-frame
    waitPhase(1);
    wr(3'd3, 8'hFF);
    do @(negedge clk); while (txd !== 1'b0);
    repeat (100) @(negedge clk);
    wr(3'd2, 8'h02);
    @(negedge clk);
    rdNow(3'd5, v); chk("R6 tdre forced", v[0], 1'b1);
    chk("R6 txd idle after abort", txd, 1'b1);
    wr(3'd3, 8'h55);
    rd(3'd5, v); chk("R6 write ignored, tdre", v[0], 1'b1);
    repeat (800) @(negedge clk);
    chk("R6 nothing sent", txd, 1'b1);

    // receive path (odd parity, two stops)
    sendRx(8'h5A, 1, 1, 0, 0);
    rd(3'd5, v); chk("R7 receive-full", v, 8'h03);
    rd(3'd4, v); chk("R7 received byte", v, 8'h5A);
    sendRx(8'hC3, 1, 1, 0, 0);
    rd(3'd5, v); chk("R10 overrun flag", v, 8'h13);
    rd(3'd4, v); chk("R10 data kept", v, 8'h5A);
    wr(3'd5, 8'h1F);
    rd(3'd5, v); chk("R13 ones leave flags", v, 8'h13);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R13 zeros clear flags", v, 8'h01);

    sendRx(8'h0F, 1, 1, 1, 0);
    rd(3'd5, v); chk("R8 parity error", v, 8'h07);
    rd(3'd4, v); chk("R8 byte stored", v, 8'h0F);
    wr(3'd5, 8'h01);

    sendRx(8'h81, 1, 1, 0, 1);
    rd(3'd5, v); chk("R9 framing error", v, 8'h0B);
    wr(3'd5, 8'h19);
    rd(3'd5, v); chk("R13 selective clear", v, 8'h09);

    sendRx(8'h77, 1, 1, 0, 0);
    wr(3'd2, 8'h00);
    rd(3'd5, v); chk("R11 flags kept after RE clear", v, 8'h0B);
    rd(3'd4, v); chk("R11 data kept after RE clear", v, 8'h77);
    sendRx(8'h12, 1, 1, 0, 0);
    rd(3'd5, v); chk("R11 no reception while off", v, 8'h0B);
    rd(3'd4, v); chk("R11 data unchanged while off", v, 8'h77);

    // R4: external 16x clock
    cmpOn = 0;
    wr(3'd0, 8'h10);
    wr(3'd2, 8'h01);
    extRun = 1;
    chk("R4 sckOe off in external mode", sckOe, 1'b0);
    repeat (8) @(negedge clk);
    wr(3'd3, 8'h96);
    begin
      int guard = 0;
      while (txd !== 1'b0 && guard < 3000) begin @(negedge clk); guard++; end
    end
    chk("R4 start bit seen", txd, 1'b0);
    repeat (32) @(negedge clk);
    chk("R4 start bit centre", txd, 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (64) @(negedge clk);
      chk("R4 data bit", txd, (8'h96 >> i) & 1);
    end
    repeat (64) @(negedge clk);
    chk("R4 stop bit", txd, 1'b1);
    extRun = 0;

    finishRun();
  end
endmodule